// File: doc/BRIEF.md
# Ring-Indicate Wake Event Router

This block gathers wake events from a set of card sockets (two by default) and presents them as a single ring/wake output. For each socket the event source depends on the type of card. A powered 16-bit card offers its ring-indicate line, qualified by that socket's ring-enable bit. Any other socket offers its card status-change event, qualified by that socket's status mask bit. The qualified events from all sockets are ORed together.

The combined wake signal and a separate power-management event (PME) request are steered onto three output pins: one shared ring/PME pin and two multifunction pins. A mux-select bit picks between two modes.

- **Mux-select clear:** both functions compete for the shared pin. When the ring output is enabled it owns that pin, and PME is blocked there.
- **Mux-select set:** the shared pin carries only PME. The ring output moves to the multifunction pin named by a select input.

All outputs are registered and reset low.

Top module: `wake_router`

## Requirements
- R1: When socket i has a powered 16-bit card (`legacyPowered[i]`=1), its `ringInd[i]` contributes to the wake signal only while `ringEn[i]`=1. In that state its `statusEvt[i]` contributes nothing.
- R2: When `legacyPowered[i]`=0, `ringInd[i]` contributes nothing. `statusEvt[i]` contributes only while `statusMask[i]`=1.
- R3: The wake signal is the OR of the qualified events of all sockets, so an event on any single socket is enough to raise it.
- R4: With `ringOutEn`=0, no wake event reaches any output pin.
- R5: With `pmeEn`=0, `pmeReq` never reaches any output pin.
- R6: With `muxSel`=0, both `mfPin` bits are 0. `sharedPin` carries the wake signal when `ringOutEn`=1, and in that case PME is suppressed. When `ringOutEn`=0, `sharedPin` carries `pmeEn & pmeReq`.
- R7: With `muxSel`=1, `sharedPin` carries `pmeEn & pmeReq`. `mfPin[altPinSel]` carries the wake signal gated by `ringOutEn`, and the other `mfPin` bit is 0.
- R8: All outputs change one clock after their inputs, and they are 0 while `rst_n`=0 (asynchronous, active-low reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ringInd | input | NUM_SOCKETS | Per-socket ring-indicate line |
| legacyPowered | input | NUM_SOCKETS | Per-socket flag: a 16-bit card is present and powered |
| statusEvt | input | NUM_SOCKETS | Per-socket card status-change / wake event |
| ringEn | input | NUM_SOCKETS | Per-socket ring-indicate enable |
| statusMask | input | NUM_SOCKETS | Per-socket status-change enable mask |
| ringOutEn | input | 1 | Global enable for the ring/wake output |
| pmeEn | input | 1 | PME function enable |
| pmeReq | input | 1 | PME request |
| muxSel | input | 1 | 0: both functions share the shared pin; 1: ring output goes to a multifunction pin |
| altPinSel | input | 1 | Index of the multifunction pin that carries the ring output |
| sharedPin | output | 1 | Shared ring/PME pin |
| mfPin | output | 2 | Multifunction pins |

## Verification
The clocked assertions assume that every control and event input is stable around the rising clock edge and carries no X after reset. Each property compares a registered output with the input state of the previous cycle.

The bench meets these assumptions by changing inputs only on the falling edge and by driving every input to a known value before reset is released. It also checks outputs only on the falling edge, which is one full register stage after the inputs were applied.

// File: rtl/wake_router_pkg.sv
package wake_router_pkg;
  localparam int ALT_PINS  = 2;
  localparam int ALT_SEL_W = (ALT_PINS > 1) ? $clog2(ALT_PINS) : 1;

  typedef struct packed {
    logic                ringToShared;
    logic                pmeToShared;
    logic [ALT_PINS-1:0] altOneHot;
  } routeStrobes_t;
endpackage

// File: rtl/wake_router_ctrl.sv
module wake_router_ctrl
  import wake_router_pkg::*;
(
  input  logic                 ringOutEn,
  input  logic                 pmeEn,
  input  logic                 muxSel,
  input  logic [ALT_SEL_W-1:0] altPinSel,
  output routeStrobes_t        strobes
);
  logic ringOnShared;
  logic ringOnAlt;

  always_comb begin
    ringOnShared = ringOutEn && !muxSel;
    ringOnAlt    = ringOutEn && muxSel;
    strobes.ringToShared = ringOnShared;
    // PME loses the shared pin whenever the ring output owns it
    strobes.pmeToShared  = pmeEn && !ringOnShared;
    strobes.altOneHot    = ringOnAlt ? (ALT_PINS'(1) << altPinSel) : '0;
  end
endmodule

// File: rtl/wake_router_dp.sv
module wake_router_dp
  import wake_router_pkg::*;
#(
  parameter int NUM_SOCKETS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SOCKETS-1:0] ringInd,
  input  logic [NUM_SOCKETS-1:0] legacyPowered,
  input  logic [NUM_SOCKETS-1:0] statusEvt,
  input  logic [NUM_SOCKETS-1:0] ringEn,
  input  logic [NUM_SOCKETS-1:0] statusMask,
  input  logic                   pmeReq,
  input  routeStrobes_t          strobes,
  output logic                   sharedPin,
  output logic [ALT_PINS-1:0]    mfPin
);
  logic [NUM_SOCKETS-1:0] socketWake;
  logic                   wakeAny;
  logic                   sharedNext;
  logic [ALT_PINS-1:0]    mfNext;

  for (genvar s = 0; s < NUM_SOCKETS; s++) begin : g_socket
    always_comb begin
      if (legacyPowered[s]) socketWake[s] = ringInd[s] && ringEn[s];      // R1
      else                  socketWake[s] = statusEvt[s] && statusMask[s]; // R2
    end
  end

  always_comb begin
    wakeAny    = |socketWake; // R3
    sharedNext = (strobes.ringToShared && wakeAny) ||
                 (strobes.pmeToShared && pmeReq);
    mfNext     = strobes.altOneHot & {ALT_PINS{wakeAny}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sharedPin <= 1'b0;
      mfPin     <= '0;
    end else begin
      sharedPin <= sharedNext;
      mfPin     <= mfNext;
    end
  end

  AST_MF_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mfPin)); // R7
endmodule

// File: rtl/wake_router.sv
module wake_router
  import wake_router_pkg::*;
#(
  parameter int NUM_SOCKETS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SOCKETS-1:0] ringInd,
  input  logic [NUM_SOCKETS-1:0] legacyPowered,
  input  logic [NUM_SOCKETS-1:0] statusEvt,
  input  logic [NUM_SOCKETS-1:0] ringEn,
  input  logic [NUM_SOCKETS-1:0] statusMask,
  input  logic                   ringOutEn,
  input  logic                   pmeEn,
  input  logic                   pmeReq,
  input  logic                   muxSel,
  input  logic [ALT_SEL_W-1:0]   altPinSel,
  output logic                   sharedPin,
  output logic [ALT_PINS-1:0]    mfPin
);
  routeStrobes_t strobes;

  wake_router_ctrl u_ctrl (
    .ringOutEn (ringOutEn),
    .pmeEn     (pmeEn),
    .muxSel    (muxSel),
    .altPinSel (altPinSel),
    .strobes   (strobes)
  );

  wake_router_dp #(.NUM_SOCKETS(NUM_SOCKETS)) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .ringInd       (ringInd),
    .legacyPowered (legacyPowered),
    .statusEvt     (statusEvt),
    .ringEn        (ringEn),
    .statusMask    (statusMask),
    .pmeReq        (pmeReq),
    .strobes       (strobes),
    .sharedPin     (sharedPin),
    .mfPin         (mfPin)
  );

  AST_RING_OFF_MF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ringOutEn |=> mfPin == '0); // R4
  AST_BOTH_OFF_SHARED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!ringOutEn && !pmeEn) |=> !sharedPin); // R5
  AST_MUX0_MF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !muxSel |=> mfPin == '0); // R6
  AST_MUX0_PME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!muxSel && !ringOutEn) |=> sharedPin == $past(pmeEn && pmeReq)); // R6
  AST_MUX1_SHARED_PME: assert property (@(posedge clk) disable iff (!rst_n)
    muxSel |=> sharedPin == $past(pmeEn && pmeReq)); // R7
endmodule

// File: tb/wake_router_tb.sv
module wake_router_tb;
  localparam int NV = 15;
  // {ringInd, legacyPowered, statusEvt, ringEn, statusMask,
  //  ringOutEn, pmeEn, pmeReq, muxSel, altPinSel, expShared, expMf[1:0]}
  localparam logic [17:0] VEC [NV] = '{
    18'b01_01_00_01_00_10000_100, // R1 ring enabled on 16-bit socket 0
    18'b01_01_00_00_00_10000_000, // R1 ring disabled
    18'b01_00_00_01_00_10000_000, // R2 ring ignored with no 16-bit card
    18'b00_00_01_00_01_10000_100, // R2 status event unmasked
    18'b00_00_01_00_00_10000_000, // R2 status event masked
    18'b10_10_00_10_00_10000_100, // R3 socket 1 alone
    18'b00_10_01_10_01_10000_100, // R3 socket 0 status, socket 1 quiet
    18'b11_11_00_11_00_00000_000, // R4 ring output disabled, mux 0
    18'b11_11_00_11_00_00011_000, // R4 ring output disabled, mux 1
    18'b00_00_00_00_00_00100_000, // R5 pme disabled
    18'b00_00_00_00_00_01100_100, // R6 pme on shared pin
    18'b00_00_00_00_00_11100_000, // R6 pme suppressed by ring owner
    18'b01_01_00_01_00_11110_101, // R7 ring on mf0, pme on shared
    18'b01_01_00_01_00_11011_010, // R7 ring on mf1, no pme
    18'b00_00_00_00_00_11111_100  // R7 pme only with mux 1
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ringInd = '0, legacyPowered = '0, statusEvt = '0, ringEn = '0, statusMask = '0;
  logic ringOutEn = 1'b0, pmeEn = 1'b0, pmeReq = 1'b0, muxSel = 1'b0;
  logic [0:0] altPinSel = '0;
  logic sharedPin;
  logic [1:0] mfPin;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wake_router u_dut (
    .clk(clk), .rst_n(rst_n), .ringInd(ringInd), .legacyPowered(legacyPowered),
    .statusEvt(statusEvt), .ringEn(ringEn), .statusMask(statusMask),
    .ringOutEn(ringOutEn), .pmeEn(pmeEn), .pmeReq(pmeReq), .muxSel(muxSel),
    .altPinSel(altPinSel), .sharedPin(sharedPin), .mfPin(mfPin)
  );

  task automatic apply(input logic [17:0] v);
    {ringInd, legacyPowered, statusEvt, ringEn, statusMask,
     ringOutEn, pmeEn, pmeReq, muxSel, altPinSel} = v[17:3];
  endtask

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if ({sharedPin, mfPin} !== exp) begin
      fails++;
      $display("FAIL %s: {shared,mf}=%b expected %b", req, {sharedPin, mfPin}, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    finishRun();
  end

  initial begin
    // R8 reset state with active inputs
    @(negedge clk);
    apply(VEC[12]);
    @(negedge clk);
    check("R8 reset", 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("vector %0d", i), VEC[i][2:0]);
    end
    // R8 one-cycle latency: output holds until the next edge
    apply(VEC[0]);
    @(posedge clk);
    @(negedge clk);
    apply(18'b0);
    #1;
    check("R8 hold before edge", 3'b100);
    @(posedge clk);
    @(negedge clk);
    check("R8 update after edge", 3'b000);
    // R8 asynchronous reset mid-run
    apply(VEC[12]);
    @(posedge clk);
    @(negedge clk);
    check("R7 pre-reset", 3'b101);
    rst_n = 1'b0;
    #1;
    check("R8 async clear", 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 status event ignored on a powered 16-bit socket
    apply(18'b00_01_01_00_01_10000_000);
    @(posedge clk);
    @(negedge clk);
    check("R1 status ignored", 3'b000);
    finishRun();
  end
endmodule